// File: doc/BRIEF.md
# Programmable Baud Tick Generator

This block divides its input clock down to the rate a serial channel needs. A 32-bit configuration word holds an enable flag, a 12-bit divisor value N and a prescale select. The prescale select places a fixed divide-by-16 stage in front of the divisor counter. Each output period is therefore S·(N+1) input cycles, where S is 1 or 16. The divisor is written as the wanted ratio minus one. The prescale stage is meant for ratios that a 12-bit count cannot reach.

Two outputs are produced. The first is a single-cycle tick at each terminal count. The second is a square wave of the same period, with its high phase as close to half the period as an integer count allows. The consumer is a serial channel that oversamples by 16, so the input is normally an internal baud reference clock.

A new word written while the generator runs does not disturb the period in progress. The divisor and prescale select are taken up only at the next terminal count, so neither output ever shows a shortened or stretched phase. Clearing the enable stops the generator and forces both outputs low.

Top module: `baud_gen_top`

## Requirements
- R1: The configuration word is decoded as follows: bit 15 is the enable, bits [12:1] are the divisor N, and bit 0 selects the divide-by-16 prescale. All other bits have no effect on either output.
- R2: From the first rising edge that samples the enable clear, tick_o and clk_o are both low, and they stay low while the enable stays clear.
- R3: Let edge 1 be the first rising edge that samples the enable set after it was clear. The first tick_o pulse is then visible after rising edge number S·(N+1)+1, with S=16 when bit 0 is set and S=1 otherwise.
- R4: While the generator is enabled with a fixed word, consecutive tick_o pulses are exactly S·(N+1) input cycles apart.
- R5: tick_o is high for exactly one cycle per period. The exception is N=0 with no prescale, where the period is one cycle and tick_o stays high continuously.
- R6: In each period clk_o is high for floor((N+1)/2)·S cycles and low for the remaining cycles, so the high phase is one step shorter when N+1 is odd. With N=0, clk_o stays low.
- R7: A word written while the generator is enabled does not change the period in progress. The new divisor and prescale select take effect from the next terminal count.
- R8: Every divisor value from 0 to 4095 is legal. N=4095 without prescale gives a period of 4096 cycles.
- R9: While reset is asserted, tick_o and clk_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input reference clock that is divided |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_i | input | 32 | Configuration word: enable, divisor, prescale select |
| tick_o | output | 1 | One-cycle pulse at each terminal count |
| clk_o | output | 1 | Square-wave output at the divided rate |

## Verification
The embedded assertions check, on every cycle, the properties that hold locally. These are: the count never exceeds the active divisor; the active divisor holds between terminal counts; the prescaler wraps cleanly; the tick is a single-cycle pulse; the square wave is high at reload; and both outputs go quiet after the enable clears. Properties that span a whole period are shown only by the bench scenarios. These include the latency from enable to first tick, the exact spacing between ticks, the high-phase length for odd and even ratios, the boundary divisors 0 and 4095, and the deferred take-up of a new word at the following terminal count. The bench measures these at the ports, for directed and randomly drawn configuration words with random values in the unused bits.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

  localparam int unsigned BG_CFG_W    = 32;
  localparam int unsigned BG_DIV_W    = 12;
  localparam int unsigned BG_DIV_LSB  = 1;
  localparam int unsigned BG_PSEL_BIT = 0;
  localparam int unsigned BG_EN_BIT   = 15;
  localparam int unsigned BG_PRE_DIV  = 16;

  typedef enum logic {
    BG_IDLE = 1'b0,
    BG_RUN  = 1'b1
  } bg_state_e;

endpackage

// File: rtl/baud_gen_prescale.sv
module baud_gen_prescale #(
  parameter int unsigned PRE_DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic psel_i,
  output logic step_o
);

  generate
    if (PRE_DIV > 1) begin : g_pre
      localparam int unsigned PW = $clog2(PRE_DIV);
      localparam logic [PW-1:0] PRE_LAST = PW'(PRE_DIV - 1);

      logic [PW-1:0] pre_q;
      logic [PW-1:0] pre_d;
      logic          pre_en;

      always_comb begin
        pre_en = 1'b0;
        pre_d  = pre_q;
        if (!run_i || !psel_i) begin
          pre_en = (pre_q != '0);
          pre_d  = '0;
        end else begin
          pre_en = 1'b1;
          pre_d  = (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pre_q <= '0;
        end else if (pre_en) begin
          pre_q <= pre_d;
        end
      end

      assign step_o = run_i && (!psel_i || (pre_q == PRE_LAST));

      AST_PRE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && psel_i && pre_q == PRE_LAST) |=> (pre_q == '0)); // R4
    end else begin : g_nopre
      logic unused_psel;
      assign unused_psel = psel_i;
      assign step_o = run_i;
    end
  endgenerate

endmodule

// File: rtl/baud_gen_divider.sv
module baud_gen_divider
  import baud_gen_pkg::*;
#(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             psel_i,
  input  logic             step_i,
  output logic             run_o,
  output logic             tick_o,
  output logic [DIV_W-1:0] div_o,
  output logic             psel_o,
  output logic             nxt_run_o,
  output logic [DIV_W-1:0] nxt_cnt_o,
  output logic [DIV_W-1:0] nxt_div_o
);

  bg_state_e        state_q, state_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             psel_q, psel_d;
  logic             tick_q, tick_d;
  logic             term;

  assign term = (state_q == BG_RUN) && step_i && (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    div_d   = div_q;
    psel_d  = psel_q;
    tick_d  = 1'b0;
    if (!en_i) begin
      state_d = BG_IDLE;
      cnt_d   = '0;
      div_d   = '0;
      psel_d  = 1'b0;
    end else if (state_q == BG_IDLE) begin
      state_d = BG_RUN;
      cnt_d   = div_i;
      div_d   = div_i;
      psel_d  = psel_i;
    end else if (term) begin
      cnt_d   = div_i;
      div_d   = div_i;
      psel_d  = psel_i;
      tick_d  = 1'b1;
    end else if (step_i) begin
      cnt_d   = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BG_IDLE;
      cnt_q   <= '0;
      div_q   <= '0;
      psel_q  <= 1'b0;
      tick_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      div_q   <= div_d;
      psel_q  <= psel_d;
      tick_q  <= tick_d;
    end
  end

  assign run_o     = (state_q == BG_RUN);
  assign tick_o    = tick_q;
  assign div_o     = div_q;
  assign psel_o    = psel_q;
  assign nxt_run_o = (state_d == BG_RUN);
  assign nxt_cnt_o = cnt_d;
  assign nxt_div_o = div_d;

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BG_RUN) |-> (cnt_q <= div_q)); // R8

  AST_DIV_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == BG_RUN) && en_i && !(step_i && cnt_q == '0)) |=> $stable(div_q) && $stable(psel_q)); // R7

  AST_TICK_RELOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |-> (cnt_q == div_q)); // R4

endmodule

// File: rtl/baud_gen_wave.sv
module baud_gen_wave #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] cnt_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             clk_o
);

  logic [DIV_W-1:0] half;
  logic             hi_d;
  logic             hi_q;

  assign half = div_i >> 1;

  always_comb begin
    hi_d = run_i && (cnt_i > half);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= 1'b0;
    end else begin
      hi_q <= hi_d;
    end
  end

  assign clk_o = hi_q;

endmodule

// File: rtl/baud_gen_top.sv
module baud_gen_top
  import baud_gen_pkg::*;
#(
  parameter int unsigned CFG_W    = BG_CFG_W,
  parameter int unsigned DIV_W    = BG_DIV_W,
  parameter int unsigned DIV_LSB  = BG_DIV_LSB,
  parameter int unsigned PSEL_BIT = BG_PSEL_BIT,
  parameter int unsigned EN_BIT   = BG_EN_BIT,
  parameter int unsigned PRE_DIV  = BG_PRE_DIV
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             tick_o,
  output logic             clk_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic             cfg_en;
  logic             cfg_psel;
  logic [DIV_W-1:0] cfg_div;
  logic             run;
  logic             step;
  logic             psel_act;
  logic [DIV_W-1:0] div_act;
  logic             nxt_run;
  logic [DIV_W-1:0] nxt_cnt;
  logic [DIV_W-1:0] nxt_div;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  assign cfg_en   = cfg_i[EN_BIT];
  assign cfg_psel = cfg_i[PSEL_BIT];
  assign cfg_div  = cfg_i[DIV_LSB +: DIV_W];

  baud_gen_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .run_i  (run && cfg_en),
    .psel_i (psel_act),
    .step_o (step)
  );

  baud_gen_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .en_i      (cfg_en),
    .div_i     (cfg_div),
    .psel_i    (cfg_psel),
    .step_i    (step),
    .run_o     (run),
    .tick_o    (tick_o),
    .div_o     (div_act),
    .psel_o    (psel_act),
    .nxt_run_o (nxt_run),
    .nxt_cnt_o (nxt_cnt),
    .nxt_div_o (nxt_div)
  );

  baud_gen_wave #(.DIV_W(DIV_W)) u_wave (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .run_i  (nxt_run),
    .cnt_i  (nxt_cnt),
    .div_i  (nxt_div),
    .clk_o  (clk_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !cfg_en |=> (!tick_o && !clk_o)); // R2

  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (tick_o && (div_act != '0 || psel_act)) |=> !tick_o); // R5

  AST_WAVE_HIGH_AT_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (tick_o && div_act != '0) |-> clk_o); // R6

  AST_RESET_LOW: assert property (@(posedge clk_i)
    !rst_n_s |-> (!tick_o && !clk_o)); // R9

endmodule

// File: tb/baud_gen_top_test.sv
module baud_gen_top_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cfg;
  logic        tick;
  logic        sclk;
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;

  always #4 clk = ~clk;

  baud_gen_top uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .cfg_i  (cfg),
    .tick_o (tick),
    .clk_o  (sclk)
  );

  function automatic logic [31:0] mk(bit en, bit ps, int n, logic [31:0] junk);
    return (junk & 32'hFFFF_6000) | (32'(en) << 15) | ((32'(n) & 32'hFFF) << 1) | 32'(ps);
  endfunction

  function automatic int exp_period(int n, bit ps);
    return (n + 1) * (ps ? 16 : 1);
  endfunction

  function automatic int exp_high(int n, bit ps);
    return ((n + 1) / 2) * (ps ? 16 : 1);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  // Disable, then write the word; returns the negedge count at which the first tick is seen.
  task automatic start(logic [31:0] w, output int k);
    cfg = w & ~32'h0000_8000;
    repeat (3) @(negedge clk);
    cfg = w;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!tick && k < 70000);
  endtask

  // Starting on a tick sample, measure up to and including the next tick sample.
  task automatic meas(output int len, output int hi, output int first_tick);
    len = 0;
    hi = 0;
    first_tick = 0;
    forever begin
      @(negedge clk);
      len++;
      if (len == 1) first_tick = int'(tick);
      if (sclk) hi++;
      if ((tick && len > 0) || len >= 70000) break;
    end
  endtask

  task automatic run_case(string tag, int n, bit ps, logic [31:0] junk);
    int k, len, hi, ft;
    start(mk(1'b1, ps, n, junk), k);
    check({tag, " R3 first tick"}, k, exp_period(n, ps) + 1);
    meas(len, hi, ft);
    check({tag, " R4 period"}, len, exp_period(n, ps));
    check({tag, " R6 high phase"}, hi, exp_high(n, ps));
    if (exp_period(n, ps) > 1) check({tag, " R5 single-cycle tick"}, ft, 0);
  endtask

  initial begin
    int k, len, hi, ft, bad_t, bad_c;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    cfg = 32'h0;
    repeat (5) @(negedge clk);
    check("R9 tick in reset", int'(tick), 0);
    check("R9 clk in reset", int'(sclk), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    run_case("even ratio", 3, 1'b0, 32'h0);
    run_case("odd ratio", 4, 1'b0, 32'hFFFF_FFFF);
    run_case("prescaled", 2, 1'b1, 32'h0);
    run_case("prescaled odd", 6, 1'b1, 32'hA5A5_5A5A);
    run_case("R8 max divisor", 4095, 1'b0, 32'h0);

    // R5/R6 divisor zero, no prescale: continuous tick, clock low
    start(mk(1'b1, 1'b0, 0, 32'h0), k);
    check("R3 N=0 first tick", k, 2);
    bad_t = 0;
    bad_c = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (!tick) bad_t++;
      if (sclk) bad_c++;
    end
    check("R5 N=0 tick continuous", bad_t, 0);
    check("R6 N=0 clk low", bad_c, 0);

    // R7 deferred take-up of a new word
    start(mk(1'b1, 1'b0, 5, 32'h0), k);
    cfg = mk(1'b1, 1'b1, 9, 32'h0);
    meas(len, hi, ft);
    check("R7 period in progress keeps old word", len, exp_period(5, 1'b0));
    meas(len, hi, ft);
    check("R7 new word after terminal count", len, exp_period(9, 1'b1));
    check("R7 new high phase", hi, exp_high(9, 1'b1));

    // R2 and R1: clear enable with junk in the unused bits and full divisor field
    start(mk(1'b1, 1'b0, 1, 32'h0), k);
    @(negedge clk);
    cfg = mk(1'b0, 1'b1, 4095, 32'hFFFF_FFFF);
    @(negedge clk);
    bad_t = 0;
    bad_c = 0;
    for (int i = 0; i < 40; i++) begin
      if (tick) bad_t++;
      if (sclk) bad_c++;
      @(negedge clk);
    end
    check("R2 tick quiet when disabled", bad_t, 0);
    check("R1 R2 clk quiet with enable clear", bad_c, 0);

    // Random configurations with random values in the unused bits (R1, R3, R4, R6)
    for (int it = 0; it < 10; it++) begin
      bit ps;
      int n;
      ps = bit'($urandom_range(0, 1));
      n = ps ? int'($urandom_range(1, 200)) : int'($urandom_range(1, 1500));
      run_case("R1 random", n, ps, $urandom());
    end

    summary();
    $finish;
  end

endmodule